// File: doc/BRIEF.md
# SDRAM Command Front End with Bank State Tracker

This block sits at the device side of a four-bank synchronous DRAM and turns the raw control pins into decoded commands. On each rising clock edge it samples clock enable, chip select, the row strobe, column strobe and write enable lines, two bank select pins and a 13-bit address. It then emits one registered command strobe with its code, target bank and address operand. For each bank it keeps an open/closed flag and the row that was opened.

Reads and writes take their burst start column from the low address bits. Activates take a full row. A precharge closes either one bank or all of them, chosen by a single address bit. Accesses that break the bank protocol produce an error pulse in place of a command strobe: a read or write to a closed bank, or an activate to a bank that is already open. Clock enable qualifies the edge after the one that samples it, as low-power modes on such devices require.

Top module: `sdram_cmd_front`

## Requirements
- R1: After reset all bank open flags are 0 and neither `cmd_stb` nor `err_stb` is asserted.
- R2: An edge with `cs_n` high produces no strobe, no error and no change to any bank state.
- R3: An activate ({ras_n,cas_n,we_n}=011) to a closed bank opens it and stores `addr[12:0]` as its row. The next cycle shows `cmd_stb`=1, `cmd_code`=011, `cmd_addr` equal to the row, and the bank's open flag set.
- R4: A read (101) or write (100) to an open bank gives `cmd_stb`=1, with `cmd_code` equal to the triple and `cmd_addr` equal to `addr[9:0]` zero-extended to 13 bits.
- R5: A read or write to a closed bank gives `err_stb`=1 and `cmd_stb`=0.
- R6: An activate to an open bank gives `err_stb`=1 and `cmd_stb`=0, and the stored row keeps its old value.
- R7: A precharge (010) with `addr[10]`=0 closes only the selected bank and strobes with code 010.
- R8: A precharge with `addr[10]`=1 closes every bank.
- R9: The bank number is {bsel[0], bsel[1]}, where bsel[0] is the most significant bit. So bsel=2'b01 addresses bank 2 and bsel=2'b10 addresses bank 1.
- R10: When `cke` is sampled low at one edge, the following edge is ignored: it gives no strobe, no error and no state change.
- R11: Refresh (001) and mode register set (000) strobe with their codes and leave bank state untouched. For mode register set, `cmd_addr` equals `addr`. No-op (111) produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable, qualifies the next edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command line |
| cas_n | input | 1 | Column strobe command line |
| we_n | input | 1 | Write enable command line |
| bsel | input | 2 | Bank select pins, bsel[0] is the bank number MSB |
| addr | input | 13 | Row, column or precharge-mode address |
| cmd_stb | output | 1 | One-cycle pulse for an accepted legal command |
| cmd_code | output | 3 | {ras_n,cas_n,we_n} of the accepted command |
| cmd_bank | output | 2 | Bank number of the command |
| cmd_addr | output | 13 | Row, zero-extended column, or raw address |
| err_stb | output | 1 | One-cycle pulse for an illegal bank access |
| bank_open | output | 4 | Per-bank open flags, bit n is bank n |
| bank_row | output | 52 | Stored rows, bank n in bits [13n+12:13n] |

## Verification
Two functions can fall on the same edge: the clock-enable suppression of an edge, and the protocol check that raises an error. The bench drives a cycle with `cke` low and then, on the suppressed edge, a read to a closed bank. Both strobes must stay low. It does the same with an activate, and the target bank must stay closed. A second overlap puts `cs_n` high under a precharge-all pattern, and the open flags must be unchanged afterwards.

// File: rtl/sdcf_pkg.sv
package sdcf_pkg;
   typedef enum logic [2:0] {
      OP_MRS = 3'b000,
      OP_REF = 3'b001,
      OP_PRE = 3'b010,
      OP_ACT = 3'b011,
      OP_WR  = 3'b100,
      OP_RD  = 3'b101,
      OP_BST = 3'b110,
      OP_NOP = 3'b111
   } op_e;
endpackage

// File: rtl/sdcf_decode.sv
module sdcf_decode
   import sdcf_pkg::*;
#(
   parameter int BANK_W = 2
) (
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic              edge_ok,
   input  logic [BANK_W-1:0] bsel,
   output op_e               op,
   output logic              take,
   output logic [BANK_W-1:0] bank
);
   // command triple straight from the strobe lines
   assign op   = op_e'({ras_n, cas_n, we_n});
   assign take = edge_ok && !cs_n;

   // first select pin is the most significant bank bit
   for (genvar i = 0; i < BANK_W; i++) begin : g_rev
      assign bank[BANK_W-1-i] = bsel[i];
   end
endmodule

// File: rtl/sdcf_bank.sv
module sdcf_bank #(
   parameter int ROW_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_en,
   input  logic             pre_en,
   input  logic [ROW_W-1:0] row_in,
   output logic             open_q,
   output logic [ROW_W-1:0] row_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         row_q  <= '0;
      end else if (pre_en) begin
         open_q <= 1'b0;
      end else if (act_en) begin
         open_q <= 1'b1;
         row_q  <= row_in;
      end
   end

   // R6: an open row is never overwritten while the bank stays open
   a_r6_row_held: assert property (@(posedge clk) disable iff (!rst_n)
      (open_q && !pre_en) |=> (open_q && row_q == $past(row_q)));

   // R3: an activate leaves the bank open with the requested row
   a_r3_act_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (act_en && !pre_en) |=> (open_q && row_q == $past(row_in)));
endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
   import sdcf_pkg::*;
#(
   parameter int BANK_W   = 2,
   parameter int ADDR_W   = 13,
   parameter int ROW_W    = 13,
   parameter int COL_W    = 10,
   parameter int PALL_BIT = 10
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cke,
   input  logic                          cs_n,
   input  logic                          ras_n,
   input  logic                          cas_n,
   input  logic                          we_n,
   input  logic [BANK_W-1:0]             bsel,
   input  logic [ADDR_W-1:0]             addr,
   output logic                          cmd_stb,
   output logic [2:0]                    cmd_code,
   output logic [BANK_W-1:0]             cmd_bank,
   output logic [ADDR_W-1:0]             cmd_addr,
   output logic                          err_stb,
   output logic [(1<<BANK_W)-1:0]        bank_open,
   output logic [(1<<BANK_W)*ROW_W-1:0]  bank_row
);
   localparam int NBANK = 1 << BANK_W;

   if (ROW_W > ADDR_W)    begin : g_bad_row $error("ROW_W exceeds ADDR_W"); end
   if (COL_W > ADDR_W)    begin : g_bad_col $error("COL_W exceeds ADDR_W"); end
   if (PALL_BIT >= ADDR_W) begin : g_bad_pa $error("PALL_BIT out of range"); end
   if (PALL_BIT < COL_W)  begin : g_bad_ov $error("PALL_BIT overlaps column"); end

   // clock enable qualifies the following edge
   logic cke_q;
   always_ff @(posedge clk) begin
      if (!rst_n) cke_q <= 1'b1;
      else        cke_q <= cke;
   end

   op_e               op;
   logic              take;
   logic [BANK_W-1:0] bank;

   sdcf_decode #(.BANK_W(BANK_W)) u_dec (
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .edge_ok(cke_q), .bsel(bsel), .op(op), .take(take), .bank(bank)
   );

   logic [NBANK-1:0] open_vec;
   logic             hit;
   logic             is_act, is_rw, is_pre, is_misc;
   logic             act_ok, rw_ok, bad, pre_all, pre_one, stb_d;

   assign hit     = open_vec[bank];
   assign is_act  = take && (op == OP_ACT);
   assign is_rw   = take && (op == OP_RD || op == OP_WR);
   assign is_pre  = take && (op == OP_PRE);
   assign is_misc = take && (op == OP_REF || op == OP_MRS);
   assign act_ok  = is_act && !hit;
   assign rw_ok   = is_rw && hit;
   assign bad     = (is_act && hit) || (is_rw && !hit);
   assign pre_all = is_pre && addr[PALL_BIT];
   assign pre_one = is_pre && !addr[PALL_BIT];
   assign stb_d   = act_ok || rw_ok || is_pre || is_misc;

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic sel_b;
      assign sel_b = (bank == BANK_W'(b));
      sdcf_bank #(.ROW_W(ROW_W)) u_bank (
         .clk(clk), .rst_n(rst_n),
         .act_en(act_ok && sel_b),
         .pre_en(pre_all || (pre_one && sel_b)),
         .row_in(addr[ROW_W-1:0]),
         .open_q(open_vec[b]),
         .row_q(bank_row[b*ROW_W +: ROW_W])
      );
   end
   assign bank_open = open_vec;

   // operand: row for activate, column for access, raw otherwise
   logic [ADDR_W-1:0] opnd;
   always_comb begin
      opnd = addr;
      if (op == OP_ACT) begin
         opnd = '0;
         opnd[ROW_W-1:0] = addr[ROW_W-1:0];
      end else if (op == OP_RD || op == OP_WR) begin
         opnd = '0;
         opnd[COL_W-1:0] = addr[COL_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_stb  <= 1'b0;
         err_stb  <= 1'b0;
         cmd_code <= 3'b111;
         cmd_bank <= '0;
         cmd_addr <= '0;
      end else begin
         cmd_stb <= stb_d;
         err_stb <= bad;
         if (stb_d) begin
            cmd_code <= op;
            cmd_bank <= bank;
            cmd_addr <= opnd;
         end
      end
   end

   // R5: strobe and error never coincide
   a_r5_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_stb && err_stb));

   // R10: an edge disqualified by clock enable yields nothing
   a_r10_dead_edge: assert property (@(posedge clk) disable iff (!rst_n)
      !cke_q |=> (!cmd_stb && !err_stb));

   // R8: precharge-all leaves every bank closed
   a_r8_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
      pre_all |=> (bank_open == '0));

   // R2: deselected edges leave bank flags alone
   a_r2_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (!cmd_stb && !err_stb && $stable(bank_open)));

   // R3: a strobed activate always shows its bank open
   a_r3_act_open: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb && cmd_code == 3'b011) |-> bank_open[cmd_bank]);
endmodule

// File: tb/sdram_cmd_front_tb.sv
module sdram_cmd_front_tb_top;
   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n, cke, cs_n, ras_n, cas_n, we_n;
   logic [1:0]  bsel;
   logic [12:0] addr;
   logic        cmd_stb, err_stb;
   logic [2:0]  cmd_code;
   logic [1:0]  cmd_bank;
   logic [12:0] cmd_addr;
   logic [3:0]  bank_open;
   logic [51:0] bank_row;

   int total = 0;
   int bad   = 0;

   always #(PERIOD/2) clk = ~clk;

   sdram_cmd_front dut_i (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .bsel(bsel), .addr(addr),
      .cmd_stb(cmd_stb), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
      .cmd_addr(cmd_addr), .err_stb(err_stb), .bank_open(bank_open),
      .bank_row(bank_row)
   );

   localparam logic [2:0] C_MRS = 3'b000, C_REF = 3'b001, C_PRE = 3'b010,
                          C_ACT = 3'b011, C_WR = 3'b100, C_RD = 3'b101,
                          C_NOP = 3'b111;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic c, input logic [2:0] rcw, input logic [1:0] b,
                      input logic [12:0] a, input logic ck);
      @(negedge clk);
      cs_n = c; {ras_n, cas_n, we_n} = rcw; bsel = b; addr = a; cke = ck;
      @(posedge clk);
      #1;
   endtask

   function automatic logic [12:0] row_of(input int n);
      return bank_row[n*13 +: 13];
   endfunction

   task automatic t_reset();
      chk("R1 open", 64'(bank_open), 64'h0);
      chk("R1 stb",  64'({cmd_stb, err_stb}), 64'h0);
   endtask

   task automatic t_activate();
      cyc(0, C_ACT, 2'b01, 13'h1ABC, 1);
      chk("R3 stb",  64'({cmd_stb, err_stb}), 64'h2);
      chk("R3 code", 64'(cmd_code), 64'(C_ACT));
      chk("R9 bank2", 64'(cmd_bank), 64'd2);
      chk("R3 addr", 64'(cmd_addr), 64'h1ABC);
      chk("R3 row2", 64'(row_of(2)), 64'h1ABC);
      cyc(0, C_ACT, 2'b10, 13'h0777, 1);
      chk("R9 bank1", 64'(cmd_bank), 64'd1);
      chk("R9 open", 64'(bank_open), 64'b0110);
      chk("R3 row1", 64'(row_of(1)), 64'h0777);
   endtask

   task automatic t_access();
      cyc(0, C_RD, 2'b01, 13'h1EA5, 1);
      chk("R4 rd stb", 64'(cmd_stb), 64'h1);
      chk("R4 rd code", 64'(cmd_code), 64'(C_RD));
      chk("R4 rd col", 64'(cmd_addr), 64'h02A5);
      cyc(0, C_WR, 2'b10, 13'h0013, 1);
      chk("R4 wr code", 64'(cmd_code), 64'(C_WR));
      chk("R4 wr bank", 64'(cmd_bank), 64'd1);
      chk("R4 wr col", 64'(cmd_addr), 64'h0013);
   endtask

   task automatic t_illegal();
      cyc(0, C_RD, 2'b00, 13'h0001, 1);
      chk("R5 closed", 64'({cmd_stb, err_stb}), 64'h1);
      cyc(0, C_ACT, 2'b01, 13'h0055, 1);
      chk("R6 dup err", 64'({cmd_stb, err_stb}), 64'h1);
      chk("R6 row kept", 64'(row_of(2)), 64'h1ABC);
      chk("R6 open", 64'(bank_open), 64'b0110);
   endtask

   task automatic t_deselect();
      cyc(1, C_PRE, 2'b00, 13'h0400, 1);
      chk("R2 stb", 64'({cmd_stb, err_stb}), 64'h0);
      chk("R2 open", 64'(bank_open), 64'b0110);
   endtask

   task automatic t_precharge();
      cyc(0, C_PRE, 2'b10, 13'h0000, 1);
      chk("R7 stb", 64'(cmd_stb), 64'h1);
      chk("R7 code", 64'(cmd_code), 64'(C_PRE));
      chk("R7 one", 64'(bank_open), 64'b0100);
      cyc(0, C_ACT, 2'b00, 13'h0001, 1);
      chk("R3 bank0", 64'(bank_open), 64'b0101);
      cyc(0, C_PRE, 2'b11, 13'h0400, 1);
      chk("R8 all", 64'(bank_open), 64'h0);
   endtask

   task automatic t_misc();
      cyc(0, C_REF, 2'b00, 13'h0000, 1);
      chk("R11 ref", 64'({cmd_stb, cmd_code}), 64'({1'b1, C_REF}));
      cyc(0, C_MRS, 2'b00, 13'h0032, 1);
      chk("R11 mrs", 64'({cmd_stb, cmd_code}), 64'({1'b1, C_MRS}));
      chk("R11 mrs addr", 64'(cmd_addr), 64'h0032);
      cyc(0, C_NOP, 2'b00, 13'h0000, 1);
      chk("R11 nop", 64'({cmd_stb, err_stb}), 64'h0);
      chk("R11 open", 64'(bank_open), 64'h0);
   endtask

   task automatic t_cke();
      cyc(0, C_NOP, 2'b00, 13'h0000, 0);
      cyc(0, C_RD, 2'b00, 13'h0000, 1);
      chk("R10 err masked", 64'({cmd_stb, err_stb}), 64'h0);
      cyc(0, C_NOP, 2'b00, 13'h0000, 0);
      cyc(0, C_ACT, 2'b11, 13'h1FFF, 1);
      chk("R10 act masked", 64'({cmd_stb, bank_open}), 64'h0);
      cyc(0, C_ACT, 2'b11, 13'h1FFF, 1);
      chk("R10 resumed", 64'(bank_open), 64'b1000);
      chk("R10 row3", 64'(row_of(3)), 64'h1FFF);
   endtask

   initial begin
      #(PERIOD * 5000);
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1;
      {ras_n, cas_n, we_n} = 3'b111; bsel = '0; addr = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      t_reset();
      t_activate();
      t_access();
      t_illegal();
      t_deselect();
      t_precharge();
      t_misc();
      t_cke();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule